// File: doc/BRIEF.md
# Real-Time-Clock Periodic Interrupt Generator

This block turns a slow reference tick into a programmable periodic event for a real-time-clock subsystem. A reference prescaler first reduces the incoming tick, which may be a fast crystal rate or an already slow 32.768 kHz rate, to a common base rate. A binary divider chain then counts base ticks. A four-bit rate code picks one tap of that chain. The chosen tap sets a periodic interrupt flag and toggles a square-wave output.

Software reaches the block through a byte-wide register port with three registers:
- a frequency register, which holds the reference select and the rate code;
- a control register, which holds the interrupt and square-wave enables;
- a flag register, which is cleared when it is read.

The alarm and update-ended events come from neighbouring blocks as single-cycle pulses. They share the flag register and the combined interrupt line.

Top module: `rtc_pi_top`

## Requirements
- R1: Address 0 is the frequency register: bits 6:4 hold the reference select and bits 3:0 hold the rate code. Bit 7 is ignored on write and reads 0. Address 1 is the control register: bit 6 is the periodic enable, bit 5 the alarm enable, bit 4 the update enable and bit 3 the square-wave enable. Its other bits read 0. Address 2 is the flag register. After reset the three registers read 0x60, 0x00 and 0x00.
- R2: The reference select sets how many reference ticks make one base tick. Select 2 uses every tick, select 1 every 32nd tick and select 0 every 128th tick.
- R3: A rate code n from 1 to 15 produces one periodic event every 2^(n-1) base ticks: code 1 at 32768 Hz, code 3 at 8192 Hz, code 6 at 1024 Hz and code 15 at 2 Hz. Code 0 produces no events.
- R4: Reference selects 6 and 7 hold the prescaler, the divider chain and the square-wave state cleared. Selects 3, 4 and 5 are inert test modes in which no base tick and no event occur.
- R5: After the chain leaves the held state, the first event under rate code n comes on exactly the 2^(n-1)-th base tick.
- R6: The square-wave output toggles on every periodic event. It reads low whenever control bit 3 is clear or the rate code is 0.
- R7: Flag bit 6 (periodic), bit 5 (alarm) and bit 4 (update-ended) each set on their event, whatever the enables hold.
- R8: Flag bit 7 reads 1 when any flag in bits 6:4 is set and its enable in control bits 6:4 is set. The irq output equals flag bit 7.
- R9: A read of address 2 returns the flags and clears them in the next cycle. An event that arrives in the same cycle as the read is kept.
- R10: Writes to address 2 and address 3 have no effect. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per reference clock period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0 when rd_en is low |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | Update-ended pulse |
| irq | output | 1 | Combined interrupt request, active high |
| sqw | output | 1 | Square-wave output |

## Verification
The bench counts square-wave edges over fixed tick bursts for every reference select and for several rate codes. An off-by-one tap or a wrong prescaler ratio would show up as a wrong edge count. It also checks that the first edge after a held divider comes on exactly the fourth tick under code 3; a chain that was not cleared would toggle early. It reads the flags while an update pulse arrives in the same cycle, which catches a clear that wins over the set and loses the event. It also checks that an alarm flag sets with its enable off but only raises irq once the enable is written.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;
  localparam int RATE_W = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_FREQ = 2'd0,
    REG_CTRL = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    REF_FAST  = 3'd0,
    REF_MID   = 3'd1,
    REF_SLOW  = 3'd2,
    REF_TST3  = 3'd3,
    REF_TST4  = 3'd4,
    REF_TST5  = 3'd5,
    REF_HOLDA = 3'd6,
    REF_HOLDB = 3'd7
  } ref_sel_e;

  typedef struct packed {
    logic per_en;
    logic alm_en;
    logic upd_en;
    logic sq_en;
  } ctrl_t;
endpackage

// File: rtl/rtc_pi_prescale.sv
module rtc_pi_prescale
  import rtc_pi_pkg::*;
#(
  parameter int FAST_DIV = 128,
  parameter int MID_DIV  = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_tick,
  input  ref_sel_e sel,
  output logic     base_tick,
  output logic     hold
);
  localparam int CNT_W = $clog2(FAST_DIV);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             run;

  always_comb begin
    case (sel)
      REF_FAST: lim = CNT_W'(FAST_DIV - 1);
      REF_MID:  lim = CNT_W'(MID_DIV - 1);
      default:  lim = '0;
    endcase
  end

  assign run       = (sel == REF_FAST) || (sel == REF_MID) || (sel == REF_SLOW);
  assign hold      = (sel == REF_HOLDA) || (sel == REF_HOLDB);
  assign base_tick = run && ref_tick && (cnt_q >= lim);

  always_comb begin
    cnt_d = cnt_q;
    if (hold)
      cnt_d = '0;
    else if (run && ref_tick)
      cnt_d = (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r2_base_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> ref_tick);
  a_r4_hold_no_base: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !base_tick);
endmodule

// File: rtl/rtc_pi_chain.sv
module rtc_pi_chain
  import rtc_pi_pkg::*;
#(
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_tick,
  input  logic          hold,
  input  logic [RW-1:0] rate,
  output logic          tap_evt,
  output logic          sq_q
);
  localparam int NCODE   = 1 << RW;
  localparam int CHAIN_W = NCODE - 2;

  logic [CHAIN_W-1:0] cnt_q, cnt_d;
  logic [NCODE-1:0]   tap_hit;
  logic               sq_d;

  assign tap_hit[0] = 1'b0;
  assign tap_hit[1] = 1'b1;
  for (genvar k = 2; k < NCODE; k++) begin : g_tap
    assign tap_hit[k] = &cnt_q[k-2:0];
  end

  assign tap_evt = base_tick && (rate != '0) && tap_hit[rate];

  always_comb begin
    cnt_d = cnt_q;
    sq_d  = sq_q;
    if (hold) begin
      cnt_d = '0;
      sq_d  = 1'b0;
    end else begin
      if (base_tick) cnt_d = cnt_q + 1'b1;
      if (tap_evt)   sq_d  = ~sq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sq_q  <= sq_d;
    end
  end

  a_r3_evt_needs_base: assert property (@(posedge clk) disable iff (!rst_n)
    tap_evt |-> base_tick);
  a_r3_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |-> !tap_evt);
  a_r6_sq_moves_on_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !tap_evt) |=> $stable(sq_q));
endmodule

// File: rtl/rtc_pi_flags.sv
module rtc_pi_flags
  import rtc_pi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       per_evt,
  input  logic       alarm_evt,
  input  logic       update_evt,
  input  logic       rd_clr,
  input  ctrl_t      en,
  output logic [2:0] flags_q,
  output logic       any
);
  logic [2:0] flags_d, set_v;

  assign set_v   = {per_evt, alarm_evt, update_evt};
  assign flags_d = (rd_clr ? 3'b000 : flags_q) | set_v;
  assign any     = |(flags_q & {en.per_en, en.alm_en, en.upd_en});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !per_evt && !alarm_evt && !update_evt) |=> (flags_q == 3'b000));
  a_r9_keep_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && update_evt) |=> flags_q[0]);
  a_r7_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> flags_q[1]);
endmodule

// File: rtl/rtc_pi_top.sv
module rtc_pi_top
  import rtc_pi_pkg::*;
#(
  parameter int FAST_DIV = 128,
  parameter int MID_DIV  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              alarm_evt,
  input  logic              update_evt,
  output logic              irq,
  output logic              sqw
);
  ref_sel_e          sel_q, sel_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  ctrl_t             ctrl_q, ctrl_d;

  logic       base_tick, hold, tap_evt, sq_q, any, rd_clr;
  logic [2:0] flags_q;

  always_comb begin
    sel_d  = sel_q;
    rate_d = rate_q;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (reg_addr_e'(addr))
        REG_FREQ: begin
          sel_d  = ref_sel_e'(wdata[6:4]);
          rate_d = wdata[RATE_W-1:0];
        end
        REG_CTRL: ctrl_d = '{per_en: wdata[6], alm_en: wdata[5],
                             upd_en: wdata[4], sq_en: wdata[3]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= REF_HOLDA;
      rate_q <= '0;
      ctrl_q <= '0;
    end else begin
      sel_q  <= sel_d;
      rate_q <= rate_d;
      ctrl_q <= ctrl_d;
    end
  end

  rtc_pi_prescale #(.FAST_DIV(FAST_DIV), .MID_DIV(MID_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sel(sel_q),
    .base_tick(base_tick), .hold(hold)
  );

  rtc_pi_chain #(.RW(RATE_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .hold(hold),
    .rate(rate_q), .tap_evt(tap_evt), .sq_q(sq_q)
  );

  assign rd_clr = rd_en && (reg_addr_e'(addr) == REG_FLAG);

  rtc_pi_flags u_flags (
    .clk(clk), .rst_n(rst_n), .per_evt(tap_evt), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .rd_clr(rd_clr), .en(ctrl_q),
    .flags_q(flags_q), .any(any)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (reg_addr_e'(addr))
        REG_FREQ: rdata = {1'b0, sel_q, rate_q};
        REG_CTRL: rdata = {1'b0, ctrl_q.per_en, ctrl_q.alm_en, ctrl_q.upd_en,
                           ctrl_q.sq_en, 3'b000};
        REG_FLAG: rdata = {any, flags_q, 4'b0000};
        default:  rdata = '0;
      endcase
    end
  end

  assign irq = any;
  assign sqw = sq_q && ctrl_q.sq_en && (rate_q != '0);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_q.per_en || ctrl_q.alm_en || ctrl_q.upd_en));
  a_r6_sqw_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.sq_en |-> !sqw);
  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_q == REF_HOLDA) || (sel_q == REF_HOLDB)) |=> !sq_q);
endmodule

// File: tb/tb_rtc_pi_top.sv
module tb_rtc_pi_top;
  logic       clk, rst_n, ref_tick, wr_en, rd_en, alarm_evt, update_evt;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq, sqw;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  rtc_pi_top dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .alarm_evt(alarm_evt), .update_evt(update_evt), .irq(irq), .sqw(sqw)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {ref select, rate code, tick count, expected square-wave edges}
  localparam bit [38:0] VEC [0:11] = '{
    {3'd2, 4'd1,  16'd10,  16'd10},  // R3 code 1
    {3'd2, 4'd2,  16'd10,  16'd5},   // R3 code 2
    {3'd2, 4'd3,  16'd20,  16'd5},   // R3 R5 code 3
    {3'd2, 4'd6,  16'd100, 16'd3},   // R3 code 6
    {3'd1, 4'd1,  16'd100, 16'd3},   // R2 mid select
    {3'd0, 4'd1,  16'd300, 16'd2},   // R2 fast select
    {3'd0, 4'd2,  16'd600, 16'd2},   // R2 R3 fast select code 2
    {3'd2, 4'd0,  16'd50,  16'd0},   // R3 code 0 off
    {3'd6, 4'd1,  16'd50,  16'd0},   // R4 hold
    {3'd7, 4'd1,  16'd50,  16'd0},   // R4 hold
    {3'd3, 4'd1,  16'd50,  16'd0},   // R4 test mode
    {3'd2, 4'd15, 16'd20,  16'd0}    // R3 code 15 slow
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; ref_tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    alarm_evt = 1'b0; update_evt = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 freq reset", v, 8'h60);
    rd(2'd1, v); chk("R1 ctrl reset", v, 8'h00);
    rd(2'd2, v); chk("R1 flag reset", v, 8'h00);
    chk("R8 irq reset", irq, 0);
    chk("R6 sqw reset", sqw, 0);

    // vector table
    for (int i = 0; i < 12; i++) begin
      logic [2:0]  vs;
      logic [3:0]  vr;
      int          n, ex, tog;
      logic        prev;
      vs = VEC[i][38:36]; vr = VEC[i][35:32];
      n  = int'(VEC[i][31:16]); ex = int'(VEC[i][15:0]);
      wr(2'd0, 8'h60);
      wr(2'd1, 8'h48);
      wr(2'd0, {1'b0, vs, vr});
      prev = sqw; tog = 0;
      for (int t = 0; t < n; t++) begin
        @(negedge clk);
        ref_tick = 1'b1;
        if (sqw != prev) tog++;
        prev = sqw;
      end
      @(negedge clk); ref_tick = 1'b0;
      if (sqw != prev) tog++;
      prev = sqw;
      @(negedge clk);
      if (sqw != prev) tog++;
      chk($sformatf("R2 R3 R4 vec%0d edges", i), tog, ex);
      chk($sformatf("R8 vec%0d irq", i), irq, (ex > 0) ? 1 : 0);
      rd(2'd2, v);
      chk($sformatf("R7 R8 vec%0d flags", i), v, (ex > 0) ? 8'hC0 : 8'h00);
      rd(2'd2, v);
      chk($sformatf("R9 vec%0d cleared", i), v, 8'h00);
    end

    // R5 first half-period after release, R6 gating
    wr(2'd0, 8'h60);
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h23);
    repeat (3) begin @(negedge clk); ref_tick = 1'b1; end
    @(negedge clk); ref_tick = 1'b0;
    chk("R5 no edge before 4th tick", sqw, 0);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    chk("R5 edge on 4th tick", sqw, 1);
    wr(2'd1, 8'h00);
    chk("R6 sqw low when disabled", sqw, 0);
    wr(2'd1, 8'h08);
    chk("R6 sqw restored", sqw, 1);
    wr(2'd0, 8'h20);
    chk("R6 sqw low at code 0", sqw, 0);
    rd(2'd2, v);

    // R7 R8 alarm without and with enable
    wr(2'd1, 8'h00);
    @(negedge clk); alarm_evt = 1'b1;
    @(negedge clk); alarm_evt = 1'b0;
    chk("R8 irq off without enable", irq, 0);
    wr(2'd1, 8'h20);
    chk("R8 irq with alarm enable", irq, 1);
    rd(2'd2, v); chk("R7 R8 alarm flags", v, 8'hA0);
    rd(2'd2, v); chk("R9 alarm cleared", v, 8'h00);
    chk("R9 irq after clear", irq, 0);

    // R9 event coinciding with read
    wr(2'd1, 8'h00);
    @(negedge clk);
    rd_en = 1'b1; addr = 2'd2; update_evt = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0; update_evt = 1'b0;
    chk("R9 read before event", v, 8'h00);
    rd(2'd2, v); chk("R9 event kept", v, 8'h10);

    // R10 ignored writes, R1 reserved bits
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R10 flag write ignored", v, 8'h00);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R10 addr3 reads zero", v, 8'h00);
    rd(2'd0, v); chk("R10 addr3 write no effect", v, 8'h20);
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R1 freq bit7 ignored", v, 8'h7F);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R1 ctrl fields", v, 8'h78);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule